// File: doc/BRIEF.md
# Canonic Signed Digit Recoder

This block takes an unsigned binary value of `WIDTH` bits and rewrites it as a string of `WIDTH+1` signed digits, each of which is -1, 0 or +1. The form it produces is the canonic one. No two neighbouring digits are both nonzero, the count of nonzero digits is the smallest possible, and for any input there is exactly one such string. It is used when a constant multiplier is planned: each nonzero digit beyond the first costs one adder or subtractor. The block therefore also reports how many nonzero digits it produced.

The recoding is a carry scan from the least significant bit upward. A stretch of consecutive ones collapses into a +1 just above the stretch and a -1 at its bottom end. A parameter selects whether the result leaves through a register stage or straight from the logic.

Top module: `csd_recoder`

## Requirements
- R1: The digit string read as the sum of digit times 2^i over positions 0..WIDTH equals `value_i`. Digit i sits in bits [2i+1:2i] of `digits_o`.
- R2: No two digits at adjacent positions are both nonzero.
- R3: `nz_count_o` equals the number of nonzero digits in `digits_o`.
- R4: Each digit is coded as {nonzero, negative}: 2'b00 is 0, 2'b10 is +1 and 2'b11 is -1. The code 2'b01 never appears.
- R5: An input of zero yields all-zero digits and a count of zero.
- R6: The digit string is the unique minimal-weight one. Its count of nonzero digits equals the least possible for the input.
- R7: With `REGISTERED`=1 the outputs reflect the input sampled at the previous rising clock edge. With `REGISTERED`=0 they follow the input in the same cycle.
- R8: With `REGISTERED`=1, an active-low `rst_n` clears both outputs to zero whatever the input.
- R9: Worked values for WIDTH=8: 15 gives +16 -1; 23 gives +32 -8 -1; 29 gives +32 -4 +1; 54 gives +64 -8 -2; 255 gives +256 -1, which uses the top digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| value_i | input | WIDTH | Unsigned value to recode |
| digits_o | output | 2*(WIDTH+1) | Signed digits, two bits per digit, digit 0 in the low bits |
| nz_count_o | output | $clog2(WIDTH+2) | Number of nonzero digits |

## Verification
Every 8-bit value is applied. Each result is compared digit by digit with a minimal-weight form that the bench derives by repeated division, which also covers the adjacency rule, the count, and the legality of every code. The hand-picked values single out distinct patterns: an isolated run, a run broken by a single zero, two runs that share a carry, and the all-ones input that must reach the extra top digit. A latency scenario changes the input between edges and checks the registered instance, which must still show the old result, against the unregistered one, which must already show the new result. A reset scenario holds a nonzero input while reset is active to show that the register ignores it.

// File: rtl/csd_pkg.sv
package csd_pkg;

    typedef enum logic [1:0] {
        DIG_ZERO = 2'b00,
        DIG_POS  = 2'b10,
        DIG_NEG  = 2'b11
    } csd_digit_e;

    localparam int DIGIT_BITS = 2;

endpackage

// File: rtl/csd_digit_cell.sv
module csd_digit_cell
    import csd_pkg::*;
(
    input  logic       bit_cur_i,
    input  logic       bit_nxt_i,
    input  logic       carry_i,
    output logic [1:0] code_o,
    output logic       carry_o
);

    logic odd;

    always_comb begin
        carry_o = (bit_cur_i & bit_nxt_i) | (bit_cur_i & carry_i) | (bit_nxt_i & carry_i);
        odd     = bit_cur_i ^ carry_i;
        if (!odd)
            code_o = DIG_ZERO;
        else if (carry_o)
            code_o = DIG_NEG;
        else
            code_o = DIG_POS;
    end

endmodule

// File: rtl/csd_nz_counter.sv
module csd_nz_counter #(
    parameter int N     = 9,
    parameter int CNT_W = 4
) (
    input  logic [N-1:0]     nz_i,
    output logic [CNT_W-1:0] count_o
);

    always_comb begin
        count_o = '0;
        for (int k = 0; k < N; k++) begin
            count_o = count_o + CNT_W'(nz_i[k]);
        end
    end

endmodule

// File: rtl/csd_recoder.sv
module csd_recoder
    import csd_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter bit REGISTERED = 1'b1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [WIDTH-1:0]                 value_i,
    output logic [DIGIT_BITS*(WIDTH+1)-1:0]  digits_o,
    output logic [$clog2(WIDTH+2)-1:0]       nz_count_o
);

    localparam int NDIG  = WIDTH + 1;
    localparam int DIG_W = DIGIT_BITS * NDIG;
    localparam int CNT_W = $clog2(WIDTH + 2);

    typedef struct packed {
        logic [DIG_W-1:0] digits;
        logic [CNT_W-1:0] count;
    } result_t;

    logic [WIDTH:0]   ext_w;
    logic [WIDTH:0]   carry_w;
    logic [DIG_W-1:0] code_w;
    logic [NDIG-1:0]  nz_w;
    logic [CNT_W-1:0] cnt_w;
    result_t          res_d;
    result_t          res_q;

    assign ext_w      = {1'b0, value_i};
    assign carry_w[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        csd_digit_cell u_cell (
            .bit_cur_i (ext_w[i]),
            .bit_nxt_i (ext_w[i+1]),
            .carry_i   (carry_w[i]),
            .code_o    (code_w[DIGIT_BITS*i +: DIGIT_BITS]),
            .carry_o   (carry_w[i+1])
        );
    end

    // Top position sees a zero input bit, so only the incoming carry can set it.
    assign code_w[DIGIT_BITS*WIDTH +: DIGIT_BITS] = carry_w[WIDTH] ? DIG_POS : DIG_ZERO;

    for (genvar i = 0; i < NDIG; i++) begin : g_nz
        assign nz_w[i] = code_w[DIGIT_BITS*i + 1];
    end

    csd_nz_counter #(
        .N     (NDIG),
        .CNT_W (CNT_W)
    ) u_count (
        .nz_i    (nz_w),
        .count_o (cnt_w)
    );

    always_comb begin
        res_d        = '0;
        res_d.digits = code_w;
        res_d.count  = cnt_w;
    end

    if (REGISTERED) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                res_q <= '0;
            else
                res_q <= res_d;
        end
    end else begin : g_comb
        assign res_q = res_d;
    end

    assign digits_o   = res_q.digits;
    assign nz_count_o = res_q.count;

endmodule

// File: rtl/csd_recoder_checker.sv
module csd_recoder_checker #(
    parameter int WIDTH      = 8,
    parameter bit REGISTERED = 1'b1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [WIDTH-1:0]             value_i,
    input logic [2*(WIDTH+1)-1:0]       digits_o,
    input logic [$clog2(WIDTH+2)-1:0]   nz_count_o
);

    localparam int NDIG = WIDTH + 1;

    logic [NDIG-1:0] nz_v;
    logic [NDIG-1:0] bad_v;

    always_comb begin
        for (int k = 0; k < NDIG; k++) begin
            nz_v[k]  = digits_o[2*k+1];
            bad_v[k] = (digits_o[2*k +: 2] == 2'b01);
        end
    end

    function automatic int recon(input logic [2*NDIG-1:0] d);
        int s;
        s = 0;
        for (int k = 0; k < NDIG; k++) begin
            if (d[2*k+1]) s = d[2*k] ? s - (1 << k) : s + (1 << k);
        end
        return s;
    endfunction

    AST_NO_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
        (nz_v & (nz_v >> 1)) == '0); // R2

    AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(nz_v) == int'(nz_count_o)); // R3

    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        bad_v == '0); // R4

    if (REGISTERED) begin : g_reg_chk
        AST_VALUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> recon(digits_o) == int'($past(value_i))); // R1
        AST_ZERO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
            (value_i == '0) |=> (digits_o == '0 && nz_count_o == '0)); // R5
    end else begin : g_comb_chk
        AST_VALUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            recon(digits_o) == int'(value_i)); // R1
        AST_ZERO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
            (value_i == '0) |-> (digits_o == '0 && nz_count_o == '0)); // R5
    end

endmodule

bind csd_recoder csd_recoder_checker #(
    .WIDTH      (WIDTH),
    .REGISTERED (REGISTERED)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .value_i    (value_i),
    .digits_o   (digits_o),
    .nz_count_o (nz_count_o)
);

// File: tb/csd_recoder_test.sv
module csd_recoder_test;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int NDIG       = W + 1;
    localparam int DIG_W      = 2 * NDIG;
    localparam int CNT_W      = $clog2(W + 2);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [W-1:0]     value = '0;
    logic [DIG_W-1:0] dig_r;
    logic [CNT_W-1:0] cnt_r;
    logic [DIG_W-1:0] dig_c;
    logic [CNT_W-1:0] cnt_c;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csd_recoder #(.WIDTH(W), .REGISTERED(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .value_i(value), .digits_o(dig_r), .nz_count_o(cnt_r));

    csd_recoder #(.WIDTH(W), .REGISTERED(1'b0)) uut_comb (
        .clk(clk), .rst_n(rst_n), .value_i(value), .digits_o(dig_c), .nz_count_o(cnt_c));

    // Minimal-weight form by repeated division: odd remainder picks +1 or -1 from v mod 4.
    function automatic logic [DIG_W-1:0] model(input int v_in);
        logic [DIG_W-1:0] r;
        int v;
        r = '0;
        v = v_in;
        for (int k = 0; k < NDIG; k++) begin
            if (v % 2 != 0) begin
                if (v % 4 == 1) begin r[2*k +: 2] = 2'b10; v = v - 1; end
                else            begin r[2*k +: 2] = 2'b11; v = v + 1; end
            end
            v = v / 2;
        end
        return r;
    endfunction

    function automatic int weight(input logic [DIG_W-1:0] d);
        int n;
        n = 0;
        for (int k = 0; k < NDIG; k++) n += int'(d[2*k+1]);
        return n;
    endfunction

    function automatic int value_of(input logic [DIG_W-1:0] d);
        int s;
        s = 0;
        for (int k = 0; k < NDIG; k++)
            if (d[2*k+1]) s = d[2*k] ? s - (1 << k) : s + (1 << k);
        return s;
    endfunction

    function automatic bit adjacent(input logic [DIG_W-1:0] d);
        bit a;
        a = 1'b0;
        for (int k = 0; k < NDIG - 1; k++) if (d[2*k+1] && d[2*k+3]) a = 1'b1;
        return a;
    endfunction

    function automatic bit has_bad(input logic [DIG_W-1:0] d);
        bit b;
        b = 1'b0;
        for (int k = 0; k < NDIG; k++) if (d[2*k +: 2] == 2'b01) b = 1'b1;
        return b;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic full_check(input int v, input logic [DIG_W-1:0] d, input logic [CNT_W-1:0] c);
        logic [DIG_W-1:0] e;
        e = model(v);
        check(value_of(d) == v, "R1 value", value_of(d), v);
        check(!adjacent(d), "R2 adjacency", d, e);
        check(int'(c) == weight(d), "R3 count", c, weight(d));
        check(!has_bad(d), "R4 code", d, e);
        check(d == e && int'(c) == weight(e), "R6 minimal form", d, e);
    endtask

    task automatic test_reset();
        value = 8'hA5;
        repeat (3) @(negedge clk);
        check(dig_r == '0, "R8 digits in reset", dig_r, 0);
        check(cnt_r == '0, "R8 count in reset", cnt_r, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dig_r == model(8'hA5), "R7 first capture", dig_r, model(8'hA5));
    endtask

    task automatic test_zero();
        value = '0;
        @(negedge clk);
        check(dig_r == '0 && cnt_r == '0, "R5 zero registered", dig_r, 0);
        check(dig_c == '0 && cnt_c == '0, "R5 zero direct", dig_c, 0);
    endtask

    task automatic example(input int v, input logic [DIG_W-1:0] e, input int n);
        value = W'(v);
        @(negedge clk);
        check(dig_r == e, "R9 example digits", dig_r, e);
        check(int'(cnt_r) == n, "R9 example count", cnt_r, n);
    endtask

    task automatic test_examples();
        logic [DIG_W-1:0] e;
        e = '0; e[9:8] = 2'b10; e[1:0] = 2'b11;                      example(15, e, 2);
        e = '0; e[11:10] = 2'b10; e[7:6] = 2'b11; e[1:0] = 2'b11;    example(23, e, 3);
        e = '0; e[11:10] = 2'b10; e[5:4] = 2'b11; e[1:0] = 2'b10;    example(29, e, 3);
        e = '0; e[13:12] = 2'b10; e[7:6] = 2'b11; e[3:2] = 2'b11;    example(54, e, 3);
        e = '0; e[17:16] = 2'b10; e[1:0] = 2'b11;                    example(255, e, 2);
    endtask

    task automatic test_latency();
        value = 8'd7;
        @(negedge clk);
        value = 8'd90;
        #1;
        check(dig_r == model(7), "R7 registered holds old", dig_r, model(7));
        check(dig_c == model(90), "R7 direct follows now", dig_c, model(90));
        @(negedge clk);
        check(dig_r == model(90), "R7 registered updated", dig_r, model(90));
    endtask

    task automatic test_exhaustive();
        for (int v = 0; v < (1 << W); v++) begin
            value = W'(v);
            @(negedge clk);
            full_check(v, dig_r, cnt_r);
            full_check(v, dig_c, cnt_c);
        end
    endtask

    initial begin
        test_reset();
        test_zero();
        test_examples();
        test_latency();
        test_exhaustive();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule